// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

The block exchanges 8-bit channels between serial time-division-multiplexed streams. Each input stream carries a frame of 128 byte-wide channels, sent one bit per clock with the most significant bit first. A frame pulse marks the first bit of channel 0 on every stream at once. Incoming bytes are collected per stream and written into a two-bank data memory, and the two banks change roles at every frame boundary.

Every output channel on every output stream has its own connection entry. The entry names a source stream and source channel, picks one of four output modes (switched data, a fixed message byte, high impedance, or a test byte), and chooses between the shortest possible delay and a constant one-frame delay. A per-stream driver-control output goes high while its stream is not driven, so that an external buffer can follow. A global output-enable input releases every output at once. A small parallel port writes the test byte, reads and writes connection entries, and reads back received bytes.

The block is used by programming the connection entries through the port and then running framed serial traffic. The enable and driver-control outputs are wired to the pad drivers of each output stream.

Top module: `tsi_switch`

## Requirements
- R1: A frame holds NCH channels of 8 bits, sent MSB first. A high `fp_i` in a clock cycle marks that cycle's input bit as bit 7 of channel 0 on all streams. The output bit for frame position p (p = 8*channel + 7 - bitnumber) is visible in the cycle after the edge at which input position p is sampled.
- R2: In switched mode with the constant-delay bit clear, output channel c carries source byte (stream, channel s) from the same frame when s < c, and from the previous frame when s >= c.
- R3: In switched mode with the constant-delay bit set, every output channel carries its source byte from the previous frame, whatever the channel numbers are.
- R4: In message mode, the output channel carries the low 8 bits of the entry, that is bits [7:0] of the source-stream and source-channel fields taken together.
- R5: In high-impedance mode, the stream's `sdo_en` is low and its `drvctl` is high for the 8 bit times of that channel. In every other mode, `sdo_en` is high and `drvctl` is low.
- R6: In test mode, the output channel carries the byte held in the test register.
- R7: While `oe_i` is low, every `sdo_en` bit is low and every `drvctl` bit is high in the same cycle, whatever the modes are.
- R8: Port addressing: with `cpu_addr` MSB 0, any offset reaches the 8-bit test register. With MSB 1 and the next bit 0, the address reaches the connection entry at {stream, channel} (lowest 7 bits = channel, next 2 = stream), for read and write. With MSB 1 and the next bit 1, the address reads the byte received at {stream, channel} in the most recently completed frame; a write there has no effect. Read data appears the cycle after the read request and holds until the next read.
- R9: After reset, `sdo_en` is all zeros, `drvctl` is all ones, `cpu_rdata` is zero and the test register reads zero.
- R10: Connection entry layout: bits [6:0] source channel, [8:7] source stream, bit 9 constant delay, bits [11:10] mode (00 switched, 01 message, 10 high impedance, 11 test).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during the first bit of a frame |
| sdi | input | NSTR | Serial input streams |
| oe_i | input | 1 | Global output enable |
| sdo | output | NSTR | Serial output data |
| sdo_en | output | NSTR | Output drive enable per stream (low = high impedance) |
| drvctl | output | NSTR | External driver control, high while the stream is not driven |
| cpu_cs | input | 1 | Port access strobe |
| cpu_we | input | 1 | Write (1) or read (0) |
| cpu_addr | input | 2+log2(NSTR)+log2(NCH) | Port address |
| cpu_wdata | input | 12 | Write data |
| cpu_rdata | output | 12 | Read data, registered |

## Verification
Two functions meet on one clock edge. At the last bit of an input channel, that channel's byte is written into the data memory, and on the same edge the entry for the next output channel is fetched. When the entry names the channel that is just being completed, the fetch and the write share one memory location. This happens with minimum delay and source channel c-1, and also at the frame boundary, where output channel 0 takes source channel 127 from the frame that is ending. A pass that wires every output channel to source channel c-1, with streams rotated and the delay mode alternating by stream, forces this case on every channel. Each received bit is compared with the byte the bench placed in the matching input frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Per-channel output behaviour held in the upper two bits of an entry.
  typedef enum logic [1:0] {
    MODE_SWITCH = 2'b00,
    MODE_MSG    = 2'b01,
    MODE_HIZ    = 2'b10,
    MODE_TEST   = 2'b11
  } tsi_mode_e;
endpackage

// File: rtl/tsi_frame_timer.sv
// Frame position counter and data-memory bank selector.
module tsi_frame_timer #(
  parameter int FRAME_BITS = 1024,
  localparam int FW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_l,
  input  logic          fp_i,
  output logic [FW-1:0] pos,
  output logic [FW-1:0] cnt_q,
  output logic          bank_q
);
  localparam logic [FW-1:0] LAST = FW'(FRAME_BITS - 1);

  logic bank_d;

  always_comb begin
    if (fp_i || cnt_q == LAST) pos = '0;
    else                       pos = cnt_q + 1'b1;
    bank_d = (pos == LAST) ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      cnt_q  <= LAST;
      bank_q <= 1'b0;
    end else begin
      cnt_q  <= pos;
      bank_q <= bank_d;
    end
  end
endmodule

// File: rtl/tsi_deser.sv
// Serial-to-parallel: the byte is complete when the current bit is its LSB.
module tsi_deser #(
  parameter int NSTR = 4
) (
  input  logic                 clk,
  input  logic                 rst_l,
  input  logic [NSTR-1:0]      sdi,
  output logic [NSTR-1:0][7:0] byte_o
);
  logic [NSTR-1:0][6:0] sh_q, sh_d;

  for (genvar i = 0; i < NSTR; i++) begin : g_lane
    assign byte_o[i] = {sh_q[i], sdi[i]};
    assign sh_d[i]   = {sh_q[i][5:0], sdi[i]};
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/tsi_ser.sv
// Parallel-to-serial with per-channel drive enable and the global gate.
module tsi_ser #(
  parameter int NSTR = 4
) (
  input  logic                 clk,
  input  logic                 rst_l,
  input  logic                 load,
  input  logic [NSTR-1:0][7:0] ld_byte,
  input  logic [NSTR-1:0]      ld_en,
  input  logic [2:0]           bitsel,
  input  logic                 oe_i,
  output logic [NSTR-1:0]      sdo,
  output logic [NSTR-1:0]      sdo_en,
  output logic [NSTR-1:0]      drvctl
);
  logic [NSTR-1:0][7:0] byte_q, byte_d;
  logic [NSTR-1:0]      en_q, en_d, bit_q, bit_d, act_q;

  always_comb begin
    byte_d = load ? ld_byte : byte_q;
    en_d   = load ? ld_en   : en_q;
    for (int i = 0; i < NSTR; i++) bit_d[i] = byte_q[i][~bitsel];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      byte_q <= '0;
      en_q   <= '0;
      bit_q  <= '0;
      act_q  <= '0;
    end else begin
      byte_q <= byte_d;
      en_q   <= en_d;
      bit_q  <= bit_d;
      act_q  <= en_q;
    end
  end

  assign sdo    = bit_q;
  assign sdo_en = act_q & {NSTR{oe_i}};
  assign drvctl = ~act_q | {NSTR{~oe_i}};
endmodule

// File: rtl/tsi_switch.sv
// Time-slot interchange: NSTR streams of NCH byte channels.
module tsi_switch #(
  parameter int NSTR = 4,
  parameter int NCH  = 128,
  localparam int STRW = $clog2(NSTR),
  localparam int CHW  = $clog2(NCH),
  localparam int AW   = 2 + STRW + CHW,
  localparam int DW   = 3 + STRW + CHW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_i,
  input  logic [NSTR-1:0] sdi,
  input  logic            oe_i,
  output logic [NSTR-1:0] sdo,
  output logic [NSTR-1:0] sdo_en,
  output logic [NSTR-1:0] drvctl,
  input  logic            cpu_cs,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata
);
  import tsi_pkg::*;

  localparam int FW = CHW + 3;

  typedef struct packed {
    tsi_mode_e       mode;
    logic            cdly;
    logic [STRW-1:0] str;
    logic [CHW-1:0]  ch;
  } ent_t;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  // framing
  logic [FW-1:0]  pos, cnt_q;
  logic           bank;
  logic [CHW-1:0] cur_ch, nxt_ch;
  logic [2:0]     bitsel;
  logic           load;

  tsi_frame_timer #(.FRAME_BITS(NCH * 8)) u_timer (
    .clk(clk), .rst_l(rst_l), .fp_i(fp_i),
    .pos(pos), .cnt_q(cnt_q), .bank_q(bank)
  );

  assign bitsel = pos[2:0];
  assign cur_ch = pos[FW-1:3];
  assign nxt_ch = cur_ch + 1'b1;
  assign load   = (bitsel == 3'd7);

  // receive side
  logic [NSTR-1:0][7:0] rx_byte;
  tsi_deser #(.NSTR(NSTR)) u_rx (
    .clk(clk), .rst_l(rst_l), .sdi(sdi), .byte_o(rx_byte)
  );

  logic [7:0] dmem_q [0:1][0:NSTR-1][0:NCH-1];
  ent_t       cmem_q [0:NSTR-1][0:NCH-1];

  always_ff @(posedge clk) begin
    if (load && rst_l) begin
      for (int i = 0; i < NSTR; i++) dmem_q[bank][i][cur_ch] <= rx_byte[i];
    end
  end

  // register port
  logic            a_mem, a_dm;
  logic [STRW-1:0] a_str;
  logic [CHW-1:0]  a_ch;
  logic [7:0]      test_q, test_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            cm_we;

  assign a_mem = cpu_addr[AW-1];
  assign a_dm  = cpu_addr[AW-2];
  assign a_str = cpu_addr[AW-3:CHW];
  assign a_ch  = cpu_addr[CHW-1:0];
  assign cm_we = rst_l && cpu_cs && cpu_we && a_mem && !a_dm;

  always_comb begin
    test_d  = test_q;
    rdata_d = rdata_q;
    if (cpu_cs && cpu_we && !a_mem) test_d = cpu_wdata[7:0];
    if (cpu_cs && !cpu_we) begin
      if (!a_mem)    rdata_d = {{(DW-8){1'b0}}, test_q};
      else if (!a_dm) rdata_d = cmem_q[a_str][a_ch];
      else           rdata_d = {{(DW-8){1'b0}}, dmem_q[~bank][a_str][a_ch]};
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      test_q  <= '0;
      rdata_q <= '0;
    end else begin
      test_q  <= test_d;
      rdata_q <= rdata_d;
    end
  end
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (cm_we) cmem_q[a_str][a_ch] <= ent_t'(cpu_wdata);
  end

  // fetch of the next output channel, one lane per output stream
  logic [NSTR-1:0][7:0] ld_byte;
  logic [NSTR-1:0]      ld_en;

  for (genvar o = 0; o < NSTR; o++) begin : g_fetch
    ent_t                ent;
    logic                tgt_bank, rd_bank, hit, en_v;
    logic [STRW+CHW-1:0] srcf;
    logic [7:0]          sw_b, out_b;

    always_comb begin
      ent      = cmem_q[o][nxt_ch];
      srcf     = {ent.str, ent.ch};
      tgt_bank = (nxt_ch == '0) ? ~bank : bank;
      rd_bank  = (ent.cdly || !(ent.ch < nxt_ch)) ? ~tgt_bank : tgt_bank;
      hit      = (rd_bank == bank) && (ent.ch == cur_ch);
      sw_b     = hit ? rx_byte[ent.str] : dmem_q[rd_bank][ent.str][ent.ch];
      out_b    = sw_b;
      en_v     = 1'b1;
      case (ent.mode)
        MODE_MSG:  out_b = srcf[7:0];
        MODE_HIZ:  begin out_b = '0; en_v = 1'b0; end
        MODE_TEST: out_b = test_q;
        default:   out_b = sw_b;
      endcase
    end

    assign ld_byte[o] = out_b;
    assign ld_en[o]   = en_v;
  end

  // transmit side
  tsi_ser #(.NSTR(NSTR)) u_tx (
    .clk(clk), .rst_l(rst_l), .load(load), .ld_byte(ld_byte),
    .ld_en(ld_en), .bitsel(bitsel), .oe_i(oe_i),
    .sdo(sdo), .sdo_en(sdo_en), .drvctl(drvctl)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NSTR = 4,
  parameter int NCH  = 128,
  parameter int DW   = 12,
  localparam int FW  = $clog2(NCH) + 3
) (
  input logic            clk,
  input logic            rst_l,
  input logic            fp_i,
  input logic            oe_i,
  input logic [FW-1:0]   cnt_q,
  input logic [FW-1:0]   pos,
  input logic            bank,
  input logic [NSTR-1:0] sdo_en,
  input logic [NSTR-1:0] drvctl,
  input logic            cpu_cs,
  input logic            cpu_we,
  input logic [DW-1:0]   cpu_rdata
);
  localparam logic [FW-1:0] LAST = FW'(NCH * 8 - 1);

  assert_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_l)
    fp_i |=> (cnt_q == '0));

  assert_bank_swap_R3: assert property (@(posedge clk) disable iff (!rst_l)
    (pos == LAST) |=> (bank != $past(bank)));

  assert_drive_steady_R5: assert property (@(posedge clk) disable iff (!rst_l)
    (oe_i && $past(oe_i) && cnt_q[2:0] != 3'd0) |-> ($stable(sdo_en) && $stable(drvctl)));

  assert_drive_pair_R5: assert property (@(posedge clk) disable iff (!rst_l)
    oe_i |-> (drvctl == ~sdo_en));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_l)
    !$past(cpu_cs && !cpu_we) |-> $stable(cpu_rdata));
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_l(rst_l), .fp_i(fp_i), .oe_i(oe_i), .cnt_q(cnt_q),
  .pos(pos), .bank(bank), .sdo_en(sdo_en), .drvctl(drvctl),
  .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int CLK_P = 10;
  localparam int NSTR  = 4;
  localparam int NCH   = 128;
  localparam int FB    = NCH * 8;
  localparam int NF    = 5;
  localparam int AW    = 11;
  localparam int DW    = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            fp_i;
  logic [NSTR-1:0] sdi;
  logic            oe_i;
  logic [NSTR-1:0] sdo, sdo_en, drvctl;
  logic            cpu_cs, cpu_we;
  logic [AW-1:0]   cpu_addr;
  logic [DW-1:0]   cpu_wdata;
  logic [DW-1:0]   cpu_rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0]    in_b  [0:NF-1][0:NSTR-1][0:NCH-1];
  logic [DW-1:0] ent_b [0:NSTR-1][0:NCH-1];
  logic [7:0]    test_b;

  always #(CLK_P/2) clk = ~clk;

  tsi_switch #(.NSTR(NSTR), .NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .sdi(sdi), .oe_i(oe_i),
    .sdo(sdo), .sdo_en(sdo_en), .drvctl(drvctl),
    .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cpu_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_cs = 1'b0;
    d = cpu_rdata;
  endtask

  function automatic logic [AW-1:0] cm_addr(int o, int c);
    return {2'b10, 2'(o), 7'(c)};
  endfunction

  // R10 layout: [6:0] channel, [8:7] stream, [9] constant delay, [11:10] mode
  task automatic sample(int f, int p, logic oe_now);
    int c, k, sf;
    logic [DW-1:0] e;
    logic [7:0] b;
    string tag, what;
    c = p / 8;
    k = p % 8;
    for (int o = 0; o < NSTR; o++) begin
      e = ent_b[o][c];
      what = $sformatf("frame %0d pos %0d stream %0d", f, p, o);
      if (!oe_now) begin
        chk("R7", DW'(sdo_en[o]), '0, {what, " en"});
        chk("R7", DW'(drvctl[o]), 1, {what, " drv"});
      end else if (e[11:10] == 2'b10) begin
        chk("R5", DW'(sdo_en[o]), '0, {what, " en"});
        chk("R5", DW'(drvctl[o]), 1, {what, " drv"});
      end else begin
        chk("R5", DW'(sdo_en[o]), 1, {what, " en"});
        chk("R5", DW'(drvctl[o]), '0, {what, " drv"});
        case (e[11:10])
          2'b00: begin
            sf  = (e[9] || int'(e[6:0]) >= c) ? f - 1 : f;
            tag = e[9] ? "R3" : "R2";
            b   = in_b[sf][e[8:7]][e[6:0]];
          end
          2'b01: begin tag = "R4"; b = e[7:0]; end
          default: begin tag = "R6"; b = test_b; end
        endcase
        chk(tag, DW'(sdo[o]), DW'(b[7-k]), {what, " data"});
      end
    end
  endtask

  // R1: fp_i with bit 7 of channel 0; MSB first; output one clock later
  task automatic run_pass(int oe_f, int lo_s, int lo_e);
    int pf, pp;
    logic poe, oe_v;
    logic [7:0] b;
    for (int f = 0; f < NF; f++)
      for (int s = 0; s < NSTR; s++)
        for (int c = 0; c < NCH; c++) in_b[f][s][c] = 8'($urandom);
    pf = -1; pp = 0; poe = 1'b1;
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < FB; p++) begin
        @(negedge clk);
        if (pf >= 1) sample(pf, pp, poe);
        fp_i = (p == 0);
        for (int s = 0; s < NSTR; s++) begin
          b = in_b[f][s][p/8];
          sdi[s] = b[7 - p%8];
        end
        oe_v = !(f == oe_f && p >= lo_s && p < lo_e);
        oe_i = oe_v;
        pf = f; pp = p; poe = oe_v;
      end
    end
    @(negedge clk);
    sample(pf, pp, poe);
    fp_i = 1'b0; sdi = '0; oe_i = 1'b1;
  endtask

  task automatic dm_readback();
    logic [DW-1:0] d;
    int s, c;
    for (int n = 0; n < 8; n++) begin
      s = n % NSTR;
      c = (n == 0) ? 0 : (n == 1) ? NCH - 1 : (n * 29) % NCH;
      cpu_read({2'b11, 2'(s), 7'(c)}, d);
      chk("R8", d, DW'(in_b[NF-1][s][c]), $sformatf("data memory s%0d c%0d", s, c));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0; fp_i = 1'b0; sdi = '0; oe_i = 1'b1;
    cpu_cs = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk("R9", DW'(sdo_en), '0, "sdo_en after reset");
    chk("R9", DW'(drvctl), DW'({NSTR{1'b1}}), "drvctl after reset");
    chk("R9", cpu_rdata, '0, "rdata after reset");
    cpu_read(11'h000, d);
    chk("R9", d, '0, "test register after reset");

    // R8 test register reached from any low address
    test_b = 8'h5C;
    cpu_write(11'h000, DW'(test_b));
    cpu_read(11'h13A, d);
    chk("R8", d, DW'(test_b), "test register alias");

    // pass 1: random entries over all modes
    for (int o = 0; o < NSTR; o++)
      for (int c = 0; c < NCH; c++) begin
        ent_b[o][c] = DW'($urandom);
        cpu_write(cm_addr(o, c), ent_b[o][c]);
      end
    for (int n = 0; n < 6; n++) begin
      cpu_read(cm_addr(n % NSTR, n * 21), d);
      chk("R8", d, ent_b[n % NSTR][n * 21], "connection entry readback");
    end
    cpu_write(11'h600, 12'hFFF);  // data memory is read-only
    run_pass(2, 300, 520);
    dm_readback();

    // pass 2: source channel c-1, rotated streams, delay alternating
    test_b = 8'hC3;
    cpu_write(11'h044, DW'(test_b));
    for (int o = 0; o < NSTR; o++)
      for (int c = 0; c < NCH; c++) begin
        ent_b[o][c] = {2'b00, 1'(o % 2), 2'((o + 1) % NSTR), 7'((c + NCH - 1) % NCH)};
        if (o == 3 && c % 16 == 5)  ent_b[o][c][11:10] = 2'b11;
        if (o == 2 && c % 16 == 9)  ent_b[o][c][11:10] = 2'b01;
        if (o == 1 && c % 16 == 12) ent_b[o][c][11:10] = 2'b10;
        cpu_write(cm_addr(o, c), ent_b[o][c]);
      end
    run_pass(3, 1000, 1024);
    dm_readback();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule